// File: doc/BRIEF.md
# Stereo Logarithmic Volume Stage with Soft Mute

This block scales a stereo stream of 20-bit signed samples by a common gain. A 6-bit attenuation code picks a level in 1 dB steps from 0 dB down to -60 dB. Each level maps to an unsigned fixed-point gain of GW bits, with GW-1 fraction bits, so full scale is 1.0. A few codes at the top of the range mean silence. Both channels are multiplied by the same gain. Each product is rounded back to 20 bits and clipped to the signed range.

Muting never cuts the signal abruptly. An internal ramp factor runs from 0 to 32 in thirty-seconds of the selected gain and moves one step per accepted sample pair. A mute request, or a silence code, walks the factor down to zero. Releasing the mute walks it back up to full. During a silence code the stage keeps the last audible level, so that level is what fades out and what later fades back in.

Samples enter and leave through valid/ready handshakes. There is one register stage, and a new input is taken whenever the output slot is empty or is being drained in the same cycle.

Top module: `vol_softmute`

## Requirements
- R1: Code 0 and code 1 both give 0 dB. Codes 2 to 51 give an attenuation of (code - 1) dB. A level of n dB uses the gain round(2^15 * 10^(-n/20)), so 0 dB is 32768.
- R2: The bottom codes are grouped as follows: 52 and 53 give -52 dB, 54 and 55 give -54 dB, 56 and 57 give -57 dB, and 58 to 60 give -60 dB.
- R3: Codes 61, 62 and 63 mean silence. While one of them is applied, the ramp factor falls exactly as it does under mute, and the last level set by a code of 60 or below is held.
- R4: The ramp factor k runs from 0 to 32 and is 32 after reset. A sample uses the gain floor(G*k/32). Each accepted sample then moves k one step down if mute is 1 or a silence code is applied, and one step up otherwise. k stops at 0 and at 32.
- R5: Each output channel is computed as (x*g + 16384) >> 15, with an arithmetic shift, where x is the input sample and g is the applied gain. The result is then saturated to the range -524288 to 524287.
- R6: Both channels of a sample pair use the same gain, so equal inputs give equal outputs.
- R7: The code and the mute bit are sampled only when a sample is accepted. A change applies in full from the next accepted sample on, and is never split within one sample pair.
- R8: in_ready is 1 when out_valid is 0 or out_ready is 1. An accepted input appears on the outputs one cycle later with out_valid set to 1. While out_valid is 1 and out_ready is 0, the outputs hold their values.
- R9: After reset, out_valid is 0, the level is 0 dB and k is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vol_code | input | 6 | Attenuation code, sampled when a sample is accepted |
| mute | input | 1 | Soft mute request, sampled when a sample is accepted |
| in_valid | input | 1 | An input sample pair is present |
| in_ready | output | 1 | The block can take an input sample pair |
| in_left | input | 20 | Left input sample, signed |
| in_right | input | 20 | Right input sample, signed |
| out_valid | output | 1 | An output sample pair is present |
| out_ready | input | 1 | Downstream takes the output sample pair |
| out_left | output | 20 | Left output sample, signed |
| out_right | output | 20 | Right output sample, signed |

## Verification
The hardest state to reach from the ports is a ramp that turns around partway. For example, a silence code arrives while the factor is still climbing after an unmute, and back-pressure stalls the stream in the middle of the turn. The level held through a silence code must also reappear correctly afterwards. Long directed runs of mute and of silence codes first drive the factor to both ends. A random phase then toggles mute and silence codes only occasionally, while in_valid and out_ready are dropped at random, so the ramp often reverses mid-way under stalls.

// File: rtl/vol_softmute.sv
module vol_softmute #(
  parameter int DW = 20,
  parameter int GW = 16,
  parameter int RAMP_LOG2 = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    vol_code,
  input  logic          mute,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_left,
  output logic [DW-1:0] out_right
);
  localparam int FB     = GW - 1;
  localparam int KMAX   = 1 << RAMP_LOG2;
  localparam int KW     = RAMP_LOG2 + 1;
  localparam int PW     = DW + GW + 1;
  localparam int SILENT = 61;

  function automatic int code_db(input int c);
    if (c <= 1)       return 0;
    else if (c <= 51) return c - 1;
    else if (c <= 53) return 52;
    else if (c <= 55) return 54;
    else if (c <= 57) return 57;
    else              return 60;
  endfunction

  function automatic logic [GW-1:0] gain_rom(input int db);
    real v;
    v = real'(1 << FB) * (10.0 ** (-real'(db) / 20.0));
    return GW'($rtoi(v + 0.5));
  endfunction

  logic [GW-1:0] lut [64];
  for (genvar i = 0; i < 64; i++) begin : g_lut
    localparam logic [GW-1:0] G = gain_rom(code_db(i));
    assign lut[i] = G;
  end

  logic [GW-1:0] level;
  logic [KW-1:0] ramp_k;

  wire acc    = in_valid && in_ready;
  wire silent = vol_code >= 6'(SILENT);
  wire down   = mute || silent;
  assign in_ready = !out_valid || out_ready;

  wire [GW-1:0]    lvl_use = silent ? level : lut[vol_code];
  wire [GW+KW-1:0] eff_w   = (GW+KW)'(lvl_use) * (GW+KW)'(ramp_k);
  wire [GW:0]      eff     = (GW+1)'(eff_w >> RAMP_LOG2);

  function automatic logic [DW-1:0] scale(input logic [DW-1:0] x, input logic [GW:0] g);
    logic signed [PW-1:0] p, s;
    p = PW'($signed(x)) * $signed({1'b0, g[GW-1:0]} | (g[GW] ? {1'b1, {GW{1'b0}}} : '0));
    s = (p + PW'(1 << (FB - 1))) >>> FB;
    if (s > PW'((1 << (DW - 1)) - 1))    return {1'b0, {(DW-1){1'b1}}};
    else if (s < -PW'(1 << (DW - 1)))    return {1'b1, {(DW-1){1'b0}}};
    else                                 return s[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
      level     <= GW'(1 << FB);
      ramp_k    <= KW'(KMAX);
    end else begin
      if (acc) begin
        out_valid <= 1'b1;
        out_left  <= scale(in_left, eff);
        out_right <= scale(in_right, eff);
        level     <= lvl_use;
        if (down && ramp_k != '0)             ramp_k <= ramp_k - 1'b1;
        else if (!down && ramp_k != KW'(KMAX)) ramp_k <= ramp_k + 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

module vol_softmute_chk #(
  parameter int DW = 20,
  parameter int RL = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    vol_code,
  input logic          mute,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_left,
  input logic [DW-1:0] in_right,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_left,
  input logic [DW-1:0] out_right,
  input logic [RL:0]   ramp_k
);
  wire acc = in_valid && in_ready;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_right)); // R8
  AST_ACC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R8
  AST_RAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_k <= (RL+1)'(1 << RL)); // R4
  AST_RAMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(ramp_k)); // R4
  AST_MUTE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mute && ramp_k != '0 |=> ramp_k == $past(ramp_k) - 1'b1); // R4
  AST_SILENT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && vol_code >= 6'd61 && ramp_k != '0 |=> ramp_k == $past(ramp_k) - 1'b1); // R3
  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ramp_k == '0 |=> out_left == '0 && out_right == '0); // R4
  AST_SAME_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_left == in_right |=> out_left == out_right); // R6
endmodule

bind vol_softmute vol_softmute_chk #(.DW(DW), .RL(RAMP_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .vol_code(vol_code), .mute(mute),
  .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
  .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left), .out_right(out_right),
  .ramp_k(ramp_k)
);

// File: tb/vol_softmute_bench.sv
module vol_softmute_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  vol_code = '0;
  logic        mute = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] in_left = '0, in_right = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [19:0] out_left, out_right;

  always #5 clk = ~clk;

  vol_softmute u_vol_softmute (
    .clk(clk), .rst_n(rst_n), .vol_code(vol_code), .mute(mute),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
  );

  int checks = 0, fails = 0;
  string tag = "R9";
  int mk = 32, mlevel = 32768;
  int eql [1024], eqr [1024];
  string eqt [1024];
  int wr = 0, rd = 0;
  bit hold_pend = 0;
  logic [19:0] hold_l, hold_r;

  function automatic int db_of(input int c);
    if (c <= 1)       return 0;
    else if (c <= 51) return c - 1;
    else if (c <= 53) return 52;
    else if (c <= 55) return 54;
    else if (c <= 57) return 57;
    else              return 60;
  endfunction

  function automatic int gain_of(input int db);
    return $rtoi(32768.0 * (10.0 ** (-real'(db) / 20.0)) + 0.5);
  endfunction

  function automatic int apply(input int x, input int g);
    longint s;
    s = (longint'(x) * longint'(g) + 16384) >>> 15;
    if (s > 524287)  s = 524287;
    if (s < -524288) s = -524288;
    return int'(s);
  endfunction

  task automatic check(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic step(input int c, input bit m, input int l, input int r, input bit iv, input bit ordy);
    int g;
    @(negedge clk);
    vol_code = 6'(c); mute = m; in_left = l[19:0]; in_right = r[19:0];
    in_valid = iv; out_ready = ordy;
    #2;
    if (hold_pend) begin
      check("R8 hold valid", int'(out_valid), 1);
      check("R8 hold left", int'(out_left), int'(hold_l));
      check("R8 hold right", int'(out_right), int'(hold_r));
      hold_pend = 0;
    end
    check("R8 in_ready", int'(in_ready), int'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (rd == wr) check("R8 unexpected output", 1, 0);
      else begin
        check({eqt[rd % 1024], " left"},  int'($signed(out_left)),  eql[rd % 1024]);
        check({eqt[rd % 1024], " right R6"}, int'($signed(out_right)), eqr[rd % 1024]);
        rd++;
      end
    end else if (out_valid) begin
      hold_pend = 1; hold_l = out_left; hold_r = out_right;
    end
    if (iv && in_ready) begin
      if (c < 61) mlevel = gain_of(db_of(c));
      g = mlevel * mk / 32;
      eql[wr % 1024] = apply(l, g);
      eqr[wr % 1024] = apply(r, g);
      eqt[wr % 1024] = tag;
      wr++;
      if (m || c >= 61) begin if (mk > 0) mk--; end
      else if (mk < 32) mk++;
    end
  endtask

  function automatic int rnd20();
    return int'($urandom) >>> 12;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int x;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R9 out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;
    #1;
    check("R9 in_ready after reset", int'(in_ready), 1);

    tag = "R9 first sample full gain";
    step(0, 0, 300000, -300000, 1, 1);

    tag = "R1 code map";
    for (int c = 0; c <= 51; c++) begin x = rnd20(); step(c, 0, x, rnd20(), 1, 1); end
    tag = "R2 grouped codes";
    for (int c = 52; c <= 60; c++) step(c, 0, 400000, -400000, 1, 1);

    tag = "R5 rounding saturation";
    step(0, 0, 524287, -524288, 1, 1);
    step(2, 0, 1, -1, 1, 1);
    step(7, 0, 3, -3, 1, 1);
    step(0, 0, -1, 1, 1, 1);

    tag = "R6 equal channels";
    for (int i = 0; i < 8; i++) begin x = rnd20(); step(i * 7, 0, x, x, 1, 1); end

    tag = "R7 code per sample";
    for (int i = 0; i < 12; i++) step(i[0] ? 40 : 5, 0, 200000, 200000, 1, 1);

    tag = "R4 mute ramp";
    for (int i = 0; i < 36; i++) step(0, 1, 262144, -262144, 1, 1);
    for (int i = 0; i < 36; i++) step(0, 0, 262144, -262144, 1, 1);

    tag = "R3 silence code ramp";
    step(10, 0, 262144, 100, 1, 1);
    for (int i = 0; i < 36; i++) step(61 + i % 3, 0, 262144, 100, 1, 1);
    for (int i = 0; i < 20; i++) step(62, 0, 262144, 100, 1, 1);
    for (int i = 0; i < 36; i++) step(62 - 62 * (i > 0 ? 1 : 0) + (i > 0 ? 30 : 0), 0, 262144, 100, 1, 1);

    tag = "R8 random handshake";
    begin
      bit m = 0; int c = 3;
      for (int i = 0; i < 4000; i++) begin
        if (($urandom % 40) == 0) m = ~m;
        if (($urandom % 25) == 0) c = int'($urandom % 64);
        x = rnd20();
        step(c, m, x, ($urandom % 4 == 0) ? x : rnd20(), ($urandom % 4) != 0, ($urandom % 3) != 0);
      end
    end

    tag = "R8 drain";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1);
    check("R8 all outputs delivered", rd, wr);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule